// File: doc/BRIEF.md
# Audio Sample FIFO with Coded Attention Thresholds

This block is a synchronous 16-slot word FIFO that sits between an audio serial transceiver and the system side. A writer pushes words in and a reader pops them out. The oldest word is always visible on the read data output. A clear input empties the queue at once.

A 2-bit code selects an attention threshold from a small nonlinear set. The block raises an attention flag once the occupancy it reports reaches that threshold. A parameter fixes the direction. As a receive buffer, the block reports how many slots hold data. As a transmit buffer, it reports how many slots are free, so that software can tell how much room is left to fill.

Pushing into a full queue and popping from an empty one are both reported as one-cycle error pulses. Neither one changes the stored contents.

Top module: `audio_fifo_atn`

## Requirements
- R1: After reset the FIFO is empty: `empty`=1, `full`=0, `ovr_err`=0, `udr_err`=0, and `slot_cnt` reads 0 in receive mode and 16 in transmit mode.
- R2: Words leave in the order they were pushed. While the FIFO is not empty, `pop_data` shows the oldest stored word, and a pop advances to the next one.
- R3: `slot_cnt` is 5 bits wide and ranges from 0 to 16. With `IS_TX`=0 it equals the number of filled slots. With `IS_TX`=1 it equals the number of empty slots.
- R4: `atn_sel` encodes the threshold as follows: 2'b00 means 1 slot, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 12. In receive mode, `atn` is 1 exactly when the filled-slot count is at least the selected threshold.
- R5: In transmit mode, `atn` is 1 exactly when the empty-slot count is at least the selected threshold. `atn` follows a change of `atn_sel` in the same cycle.
- R6: When `clr` is high at a rising edge, the FIFO becomes empty after that edge, whatever `push` and `pop` are doing. No error is flagged for that cycle.
- R7: A push while `full` is set (and `clr` is low) is dropped. The stored words and the count stay unchanged, and `ovr_err` is high for the one cycle after that edge.
- R8: A pop while `empty` is set (and `clr` is low) is ignored, and `udr_err` is high for the one cycle after that edge.
- R9: When the FIFO is neither full nor empty, a push and a pop at the same edge are both performed and the count does not change. When it is full, the pop is performed and the push is dropped as in R7. When it is empty, the push is performed and the pop is ignored as in R8.
- R10: `full` is 1 exactly when 16 slots are filled. `empty` is 1 exactly when none are filled. The two are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the queue, takes priority over push and pop |
| push | input | 1 | Write `push_data` into the queue |
| push_data | input | DATA_W | Word to write |
| pop | input | 1 | Remove the oldest word |
| pop_data | output | DATA_W | Oldest stored word |
| atn_sel | input | 2 | Threshold code: 00=1, 01=4, 10=8, 11=12 slots |
| slot_cnt | output | 5 | Filled slots (receive) or empty slots (transmit) |
| atn | output | 1 | Reported count is at or above the selected threshold |
| full | output | 1 | All slots filled |
| empty | output | 1 | No slot filled |
| ovr_err | output | 1 | One-cycle pulse after a dropped push |
| udr_err | output | 1 | One-cycle pulse after an ignored pop |

## Verification
A push, pop or clear changes `slot_cnt`, `full`, `empty` and `pop_data` at the rising edge that samples it. The error pulses appear in the cycle after that edge, and `atn` moves with `atn_sel` in the same cycle, with no register in between. The bench applies each stimulus at a falling edge and runs a queue model of the same step. At the next falling edge, one full cycle later, it compares every output of a receive instance and a transmit instance with the model. This way each registered result is sampled exactly one edge after its cause, and the combinational `atn` is sampled with the threshold code that is being held at that moment.

// File: rtl/audio_fifo_atn.sv
module audio_fifo_atn #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 16,
  parameter bit IS_TX  = 1'b0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic [1:0]        atn_sel,
  output logic [CNT_W-1:0]  slot_cnt,
  output logic              atn,
  output logic              full,
  output logic              empty,
  output logic              ovr_err,
  output logic              udr_err
);

  localparam int STEP = DEPTH / 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;
  logic [CNT_W-1:0]  level;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill == CNT_W'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !clr && !full;
  assign do_pop  = pop  && !clr && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_err <= 1'b0;
      udr_err <= 1'b0;
    end else begin
      ovr_err <= push && !clr && full;
      udr_err <= pop  && !clr && empty;
    end
  end

  always_comb begin
    case (atn_sel)
      2'b00:   level = CNT_W'(1);
      2'b01:   level = CNT_W'(STEP);
      2'b10:   level = CNT_W'(2 * STEP);
      default: level = CNT_W'(3 * STEP);
    endcase
  end

  generate
    if (IS_TX) begin : g_tx
      assign slot_cnt = CNT_W'(DEPTH) - fill;
    end else begin : g_rx
      assign slot_cnt = fill;
    end
  endgenerate

  assign atn = (slot_cnt >= level);

endmodule

module audio_fifo_atn_chk #(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             push,
  input logic             pop,
  input logic [1:0]       atn_sel,
  input logic [CNT_W-1:0] slot_cnt,
  input logic             atn,
  input logic             full,
  input logic             empty,
  input logic             ovr_err,
  input logic             udr_err
);

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !ovr_err && !udr_err)); // R6

  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> ovr_err); // R7

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (full && $stable(slot_cnt))); // R7

  AST_UDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr) |=> udr_err); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R10

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= CNT_W'(DEPTH)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full && !clr) |=>
      (IS_TX ? (slot_cnt + 1'b1 == $past(slot_cnt)) : (slot_cnt == $past(slot_cnt) + 1'b1))); // R3

  AST_ATN_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (atn_sel == 2'b00) |-> (atn == (IS_TX ? !full : !empty))); // R4

endmodule

bind audio_fifo_atn audio_fifo_atn_chk #(.DEPTH(DEPTH), .IS_TX(IS_TX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop), .atn_sel(atn_sel),
  .slot_cnt(slot_cnt), .atn(atn), .full(full), .empty(empty),
  .ovr_err(ovr_err), .udr_err(udr_err)
);

// File: tb/tb_audio_fifo_atn.sv
module tb_audio_fifo_atn;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, push = 1'b0, pop = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [1:0] atn_sel = 2'b00;

  logic [DW-1:0] rx_data, tx_data;
  logic [4:0] rx_cnt, tx_cnt;
  logic rx_atn, tx_atn, rx_full, tx_full, rx_empty, tx_empty;
  logic rx_ovr, tx_ovr, rx_udr, tx_udr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int q[$];
  bit exp_ovr = 1'b0, exp_udr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_fifo_atn #(.DATA_W(DW), .DEPTH(DEPTH), .IS_TX(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(rx_data), .atn_sel(atn_sel), .slot_cnt(rx_cnt),
    .atn(rx_atn), .full(rx_full), .empty(rx_empty), .ovr_err(rx_ovr), .udr_err(rx_udr));

  audio_fifo_atn #(.DATA_W(DW), .DEPTH(DEPTH), .IS_TX(1'b1)) dut_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(tx_data), .atn_sel(atn_sel), .slot_cnt(tx_cnt),
    .atn(tx_atn), .full(tx_full), .empty(tx_empty), .ovr_err(tx_ovr), .udr_err(tx_udr));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int thr(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic compare_all();
    int n = q.size();
    chk(rx_cnt == 5'(n), "R3 rx filled count", rx_cnt, n);
    chk(tx_cnt == 5'(DEPTH - n), "R3 tx empty count", tx_cnt, DEPTH - n);
    chk(rx_atn == (n >= thr(atn_sel)), "R4 rx attention", rx_atn, n >= thr(atn_sel));
    chk(tx_atn == ((DEPTH - n) >= thr(atn_sel)), "R5 tx attention", tx_atn, (DEPTH - n) >= thr(atn_sel));
    chk(rx_full == (n == DEPTH) && tx_full == (n == DEPTH), "R10 full", rx_full, n == DEPTH);
    chk(rx_empty == (n == 0) && tx_empty == (n == 0), "R10 empty", rx_empty, n == 0);
    chk(rx_ovr == exp_ovr && tx_ovr == exp_ovr, "R7 overrun pulse", rx_ovr, exp_ovr);
    chk(rx_udr == exp_udr && tx_udr == exp_udr, "R8 underrun pulse", rx_udr, exp_udr);
    if (n > 0) begin
      chk(rx_data == DW'(q[0]) && tx_data == DW'(q[0]), "R2 head word", rx_data, q[0]);
    end
  endtask

  task automatic cyc(input bit c, input bit p, input bit r, input int d, input logic [1:0] s);
    int n;
    @(negedge clk);
    compare_all();
    clr = c; push = p; pop = r; push_data = DW'(d); atn_sel = s;
    n = q.size();
    exp_ovr = !c && p && (n == DEPTH);
    exp_udr = !c && r && (n == 0);
    if (c) q.delete();
    else begin
      if (r && n > 0) void'(q.pop_front());
      if (p && n < DEPTH) q.push_back(d);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 20000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rx_empty && !rx_full && rx_cnt == 0, "R1 rx reset", rx_cnt, 0);
    chk(tx_empty && tx_cnt == 5'd16, "R1 tx reset", tx_cnt, 16);
    chk(!rx_ovr && !rx_udr && !tx_ovr && !tx_udr, "R1 error flags", rx_ovr, 0);
    rst_n = 1'b1;

    // R2 R4 fill to full, sweeping threshold codes
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, 'h100 + i * 7, 2'(i % 4));
    for (int s = 0; s < 4; s++) cyc(0, 0, 0, 0, 2'(s));
    // R7 push while full dropped, and push+pop while full
    cyc(0, 1, 0, 'hBAD, 2'b11);
    cyc(0, 1, 0, 'hBAD, 2'b11);
    cyc(0, 1, 1, 'hBEEF, 2'b10);
    cyc(0, 0, 0, 0, 2'b10);
    // R2 R5 drain with varied codes
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0, 2'(3 - i % 4));
    // R8 pop while empty, push+pop while empty
    cyc(0, 0, 1, 0, 2'b00);
    cyc(0, 0, 1, 0, 2'b01);
    cyc(0, 1, 1, 'h55, 2'b00);
    // R9 simultaneous push and pop in the middle
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 'h200 + i, 2'b01);
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, 'h300 + i, 2'(i % 4));
    // R6 clear with push and pop pending
    cyc(1, 1, 1, 'h777, 2'b00);
    cyc(0, 0, 0, 0, 2'b00);
    // R6 clear on full, with push
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, 'h400 + i, 2'b10);
    cyc(1, 1, 0, 'h999, 2'b11);
    cyc(0, 0, 1, 0, 2'b11);
    // mixed pattern with pointer wrap
    for (int i = 0; i < 60; i++) cyc(0, (i % 3) != 2, (i % 4) == 1, 'h500 + i, 2'(i / 5));
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 0, 2'(i));
    cyc(0, 0, 0, 0, 2'b00);
    @(negedge clk);
    compare_all();
    done = 1'b1;
    finish_run();
  end
endmodule